// File: doc/BRIEF.md
# Serial Multiply/Divide Unit

This block is a small arithmetic engine that computes an unsigned product or an unsigned quotient and remainder by handling one bit on each clock edge. Both operations use the same two result registers: one holds the running product or the remainder, the other holds the multiplier as it is consumed or the quotient as it is built. A single operand shift register serves both operations. It moves toward the high end while multiplying and toward the low end while dividing.

A caller pulses `start_i` for one cycle with the operation select and the operands. That edge loads the registers. One step follows on each later edge, while the step countdown for the chosen operation is non-zero. `busy_o` stays high until the last step has run. The result registers can be read at every cycle, so partial values are visible while an operation is still running. A new start pulse always wins: it discards any operation in progress and loads the new operands.

Top module: `serial_muldiv`

## Requirements
- R1: After synchronous reset, `prod_rem_o`, `quot_mplr_o` and `busy_o` are all zero.
- R2: A start with `op_i`=0 (multiply) loads 0 into the product register, the low N bits of `opnd_wide_i` (upper bits ignored) into the multiplier register, and `opnd_narrow_i` into the shift register, and arms N multiply steps.
- R3: In each multiply step, the shift register is added to the product register when bit 0 of the multiplier register is 1. The multiplier register then shifts right by one and the shift register shifts left by one.
- R4: After the N multiply steps, `prod_rem_o` equals the full 2N-bit product and `quot_mplr_o` is zero.
- R5: A start with `op_i`=1 (divide) loads `opnd_wide_i` as the remainder, zero into the quotient register, and `opnd_narrow_i` shifted left by 2N bits into the shift register, and arms 2N divide steps.
- R6: In each divide step, the quotient shifts left by one and the shift register shifts right by one. If the remainder is then at least the shift register, the shift register is subtracted from the remainder and quotient bit 0 is set.
- R7: After the 2N divide steps with a non-zero divisor, `quot_mplr_o` is the integer quotient and `prod_rem_o` is the remainder.
- R8: A divide by zero ends with `quot_mplr_o` all ones and `prod_rem_o` equal to the dividend.
- R9: A start pulse while the unit is busy abandons the running operation and begins the new one from freshly loaded operands.
- R10: With no start pulse and no step pending, both result registers hold their values.
- R11: `busy_o` rises on the edge that takes the start pulse and stays high for exactly N cycles for a multiply and 2N cycles for a divide.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | One-cycle pulse that loads operands and begins an operation |
| op_i | input | 1 | Operation select: 0 multiply, 1 divide |
| opnd_wide_i | input | 2N | Dividend, or multiplier in the low N bits |
| opnd_narrow_i | input | N | Multiplicand or divisor |
| prod_rem_o | output | 2N | Product or remainder register |
| quot_mplr_o | output | 2N | Multiplier or quotient register |
| busy_o | output | 1 | High while a step countdown is non-zero |

## Verification
The bench builds the unit at its default N=8. That gives 16-bit results, 8 multiply steps and 16 divide steps, so the extreme operands fit in one short run: 255 times 255, 65535 divided by 1, a divisor larger than the dividend, and a zero divisor. Every intermediate register value is compared each cycle against a behavioural model. This exposes faults in a single step that a check on the final result alone could hide, and it also covers a restart in the middle of an operation.

// File: rtl/serial_muldiv_pkg.sv
package serial_muldiv_pkg;
  typedef enum logic {
    OP_MUL = 1'b0,
    OP_DIV = 1'b1
  } smd_op_e;
endpackage

// File: rtl/smd_seq.sv
module smd_seq
  import serial_muldiv_pkg::*;
#(
  parameter int MUL_STEPS = 8,
  parameter int DIV_STEPS = 16,
  parameter int CNT_W     = 5
) (
  input  logic clk,
  input  logic rst,
  input  logic start_i,
  input  logic op_i,
  output logic mul_run_o,
  output logic div_run_o,
  output logic busy_o
);
  localparam logic [CNT_W-1:0] MUL_LOAD = CNT_W'(MUL_STEPS);
  localparam logic [CNT_W-1:0] DIV_LOAD = CNT_W'(DIV_STEPS);

  logic [CNT_W-1:0] mcnt_q, dcnt_q, mcnt_n, dcnt_n;
  logic             busy_q, busy_n;
  smd_op_e          op_sel;

  assign op_sel = smd_op_e'(op_i);

  always_comb begin
    mcnt_n = (mcnt_q != '0) ? mcnt_q - 1'b1 : '0;
    dcnt_n = (dcnt_q != '0) ? dcnt_q - 1'b1 : '0;
    if (start_i) begin
      mcnt_n = (op_sel == OP_MUL) ? MUL_LOAD : '0;
      dcnt_n = (op_sel == OP_DIV) ? DIV_LOAD : '0;
    end
    busy_n = (mcnt_n != '0) || (dcnt_n != '0);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mcnt_q <= '0;
      dcnt_q <= '0;
      busy_q <= 1'b0;
    end else begin
      mcnt_q <= mcnt_n;
      dcnt_q <= dcnt_n;
      busy_q <= busy_n;
    end
  end

  assign mul_run_o = (mcnt_q != '0);
  assign div_run_o = (dcnt_q != '0);
  assign busy_o    = busy_q;

  a_r11_busy_matches_counts: assert property (@(posedge clk) disable iff (rst)
    busy_q == ((mcnt_q != '0) || (dcnt_q != '0)));
  a_r9_single_countdown: assert property (@(posedge clk) disable iff (rst)
    !((mcnt_q != '0) && (dcnt_q != '0)));
  a_r2_mul_armed: assert property (@(posedge clk) disable iff (rst)
    (start_i && !op_i) |=> (mcnt_q == MUL_LOAD && dcnt_q == '0));
  a_r5_div_armed: assert property (@(posedge clk) disable iff (rst)
    (start_i && op_i) |=> (dcnt_q == DIV_LOAD && mcnt_q == '0));
  a_r11_mul_countdown: assert property (@(posedge clk) disable iff (rst)
    (!start_i && mcnt_q != '0) |=> (mcnt_q == $past(mcnt_q) - 1'b1));
endmodule

// File: rtl/smd_mul_stage.sv
module smd_mul_stage #(
  parameter int W    = 16,
  parameter int SH_W = 24
) (
  input  logic [W-1:0]    prod_i,
  input  logic [W-1:0]    mplr_i,
  input  logic [SH_W-1:0] shf_i,
  output logic [W-1:0]    prod_o,
  output logic [W-1:0]    mplr_o,
  output logic [SH_W-1:0] shf_o
);
  always_comb begin
    prod_o = mplr_i[0] ? prod_i + shf_i[W-1:0] : prod_i;
    mplr_o = mplr_i >> 1;
    shf_o  = shf_i << 1;
  end
endmodule

// File: rtl/smd_div_stage.sv
module smd_div_stage #(
  parameter int W    = 16,
  parameter int SH_W = 24
) (
  input  logic [W-1:0]    rem_i,
  input  logic [W-1:0]    quot_i,
  input  logic [SH_W-1:0] shf_i,
  output logic [W-1:0]    rem_o,
  output logic [W-1:0]    quot_o,
  output logic [SH_W-1:0] shf_o
);
  localparam int PAD = SH_W - W;

  logic [SH_W-1:0] shf_dn;
  logic [SH_W-1:0] rem_ext;
  logic            fits;

  always_comb begin
    shf_dn  = shf_i >> 1;
    rem_ext = {{PAD{1'b0}}, rem_i};
    fits    = (rem_ext >= shf_dn);
    shf_o   = shf_dn;
    if (fits) begin
      rem_o  = rem_i - shf_dn[W-1:0];
      quot_o = {quot_i[W-2:0], 1'b1};
    end else begin
      rem_o  = rem_i;
      quot_o = {quot_i[W-2:0], 1'b0};
    end
  end
endmodule

// File: rtl/serial_muldiv.sv
module serial_muldiv
  import serial_muldiv_pkg::*;
#(
  parameter int N = 8
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           start_i,
  input  logic           op_i,
  input  logic [2*N-1:0] opnd_wide_i,
  input  logic [N-1:0]   opnd_narrow_i,
  output logic [2*N-1:0] prod_rem_o,
  output logic [2*N-1:0] quot_mplr_o,
  output logic           busy_o
);
  localparam int W         = 2 * N;
  localparam int SH_W      = W + N;
  localparam int MUL_STEPS = N;
  localparam int DIV_STEPS = W;
  localparam int CNT_W     = $clog2(DIV_STEPS + 1);

  logic [W-1:0]    prod_q, quot_q;
  logic [SH_W-1:0] shf_q;
  logic            mul_run, div_run;
  logic [W-1:0]    m_prod, m_quot, d_rem, d_quot;
  logic [SH_W-1:0] m_shf, d_shf;
  smd_op_e         op_sel;

  assign op_sel = smd_op_e'(op_i);

  smd_seq #(
    .MUL_STEPS(MUL_STEPS),
    .DIV_STEPS(DIV_STEPS),
    .CNT_W    (CNT_W)
  ) u_seq (
    .clk      (clk),
    .rst      (rst),
    .start_i  (start_i),
    .op_i     (op_i),
    .mul_run_o(mul_run),
    .div_run_o(div_run),
    .busy_o   (busy_o)
  );

  smd_mul_stage #(.W(W), .SH_W(SH_W)) u_mul (
    .prod_i(prod_q), .mplr_i(quot_q), .shf_i(shf_q),
    .prod_o(m_prod), .mplr_o(m_quot), .shf_o(m_shf)
  );

  smd_div_stage #(.W(W), .SH_W(SH_W)) u_div (
    .rem_i (prod_q), .quot_i(quot_q), .shf_i(shf_q),
    .rem_o (d_rem),  .quot_o(d_quot), .shf_o(d_shf)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      prod_q <= '0;
      quot_q <= '0;
      shf_q  <= '0;
    end else if (start_i) begin
      if (op_sel == OP_MUL) begin
        prod_q <= '0;
        quot_q <= {{(W-N){1'b0}}, opnd_wide_i[N-1:0]};
        shf_q  <= {{(SH_W-N){1'b0}}, opnd_narrow_i};
      end else begin
        prod_q <= opnd_wide_i;
        quot_q <= '0;
        shf_q  <= {opnd_narrow_i, {W{1'b0}}};
      end
    end else if (mul_run) begin
      prod_q <= m_prod;
      quot_q <= m_quot;
      shf_q  <= m_shf;
    end else if (div_run) begin
      prod_q <= d_rem;
      quot_q <= d_quot;
      shf_q  <= d_shf;
    end
  end

  assign prod_rem_o  = prod_q;
  assign quot_mplr_o = quot_q;

  a_r10_idle_hold: assert property (@(posedge clk) disable iff (rst)
    (!start_i && !busy_o) |=> ($stable(prod_rem_o) && $stable(quot_mplr_o)));
  a_r3_mplr_shift: assert property (@(posedge clk) disable iff (rst)
    (!start_i && mul_run) |=> (quot_mplr_o == ($past(quot_mplr_o) >> 1)));
  a_r3_prod_monotone: assert property (@(posedge clk) disable iff (rst)
    (!start_i && mul_run) |=> (prod_rem_o >= $past(prod_rem_o)));
  a_r6_quot_shift: assert property (@(posedge clk) disable iff (rst)
    (!start_i && div_run) |=> (quot_mplr_o[W-1:1] == $past(quot_mplr_o[W-2:0])));
  a_r6_rem_shrinks: assert property (@(posedge clk) disable iff (rst)
    (!start_i && div_run) |=> (prod_rem_o <= $past(prod_rem_o)));
  a_r2_mul_load: assert property (@(posedge clk) disable iff (rst)
    (start_i && !op_i) |=> (prod_rem_o == '0));
endmodule

// File: tb/serial_muldiv_tb.sv
module serial_muldiv_tb;
  localparam int N = 8;
  localparam int W = 2 * N;
  localparam longint WMASK = (64'd1 << W) - 1;
  localparam longint NMASK = (64'd1 << N) - 1;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         start_i = 1'b0;
  logic         op_i = 1'b0;
  logic [W-1:0] opnd_wide_i = '0;
  logic [N-1:0] opnd_narrow_i = '0;
  logic [W-1:0] prod_rem_o, quot_mplr_o;
  logic         busy_o;

  int checks = 0;
  int fails  = 0;
  int wd     = 0;

  longint m_p = 0, m_q = 0, m_s = 0;
  int     m_mc = 0, m_dc = 0;
  string  tag = "R1";

  always #2 clk = ~clk;

  serial_muldiv #(.N(N)) u_dut (
    .clk(clk), .rst(rst), .start_i(start_i), .op_i(op_i),
    .opnd_wide_i(opnd_wide_i), .opnd_narrow_i(opnd_narrow_i),
    .prod_rem_o(prod_rem_o), .quot_mplr_o(quot_mplr_o), .busy_o(busy_o)
  );

  // behavioural reference, advanced on each rising edge
  always @(posedge clk) begin
    if (rst) begin
      m_p = 0; m_q = 0; m_s = 0; m_mc = 0; m_dc = 0; tag = "R1";
    end else if (start_i) begin
      if (op_i) begin
        m_p = longint'(opnd_wide_i); m_q = 0;
        m_s = longint'(opnd_narrow_i) << W; m_dc = W; m_mc = 0; tag = "R5";
      end else begin
        m_p = 0; m_q = longint'(opnd_wide_i) & NMASK;
        m_s = longint'(opnd_narrow_i); m_mc = N; m_dc = 0; tag = "R2";
      end
    end else if (m_mc > 0) begin
      if (m_q % 2 == 1) m_p = (m_p + (m_s & WMASK)) & WMASK;
      m_q = m_q / 2; m_s = m_s * 2; m_mc--; tag = "R3";
    end else if (m_dc > 0) begin
      m_s = m_s / 2; m_q = (m_q * 2) & WMASK;
      if (m_p >= m_s) begin m_p = m_p - m_s; m_q = m_q + 1; end
      m_dc--; tag = "R6";
    end else begin
      tag = "R10";
    end
  end

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    wd++;
    if (wd > 150000) begin
      checks++; fails++;
      $display("FAIL watchdog: run did not finish (actual %0d cycles, expected < 150000)", wd);
      report();
    end
  end

  task automatic chk(string req, longint act, longint exp, string what);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
    chk(tag, longint'(prod_rem_o), m_p, "prod_rem");
    chk(tag, longint'(quot_mplr_o), m_q, "quot_mplr");
    chk("R11", longint'(busy_o), longint'((m_mc > 0) || (m_dc > 0)), "busy");
  endtask

  task automatic pulse(logic op, logic [W-1:0] wide, logic [N-1:0] nar);
    start_i = 1'b1; op_i = op; opnd_wide_i = wide; opnd_narrow_i = nar;
    tick();
    start_i = 1'b0;
  endtask

  task automatic finish_op(logic op, longint wide, longint nar);
    int n = 0;
    while (busy_o && n < 100) begin tick(); n++; end
    chk("R11", n, op ? W : N, "busy cycles");
    if (!op) begin
      chk("R4", longint'(prod_rem_o), (wide & NMASK) * nar, "product");
      chk("R4", longint'(quot_mplr_o), 0, "multiplier drained");
    end else if (nar == 0) begin
      chk("R8", longint'(quot_mplr_o), WMASK, "div0 quotient");
      chk("R8", longint'(prod_rem_o), wide, "div0 remainder");
    end else begin
      chk("R7", longint'(quot_mplr_o), wide / nar, "quotient");
      chk("R7", longint'(prod_rem_o), wide % nar, "remainder");
    end
  endtask

  task automatic run(logic op, logic [W-1:0] wide, logic [N-1:0] nar);
    pulse(op, wide, nar);
    finish_op(op, longint'(wide), longint'(nar));
  endtask

  initial begin
    longint lcg = 64'h1234_5678;
    logic [W-1:0] hold_p, hold_q;
    repeat (3) @(posedge clk);
    #1;
    rst = 1'b0;
    // R1: reset state seen before any start
    chk("R1", longint'(prod_rem_o), 0, "prod after reset");
    chk("R1", longint'(quot_mplr_o), 0, "quot after reset");
    chk("R1", longint'(busy_o), 0, "busy after reset");
    tick();

    // R2/R3/R4: multiply, upper bits of the wide operand must be ignored
    run(1'b0, 16'hA55A, 8'hC3);
    run(1'b0, 16'h00FF, 8'hFF);
    run(1'b0, 16'h0000, 8'h77);
    run(1'b0, 16'h0013, 8'h00);

    // R5/R6/R7: divide
    run(1'b1, 16'd50000, 8'd7);
    run(1'b1, 16'hFFFF, 8'd1);
    run(1'b1, 16'd100, 8'd200);
    run(1'b1, 16'hFFFF, 8'hFF);
    // R8: divide by zero
    run(1'b1, 16'd1234, 8'd0);
    run(1'b1, 16'd0, 8'd0);

    // R10: idle cycles leave registers untouched
    hold_p = prod_rem_o; hold_q = quot_mplr_o;
    repeat (5) tick();
    chk("R10", longint'(prod_rem_o), longint'(hold_p), "idle prod hold");
    chk("R10", longint'(quot_mplr_o), longint'(hold_q), "idle quot hold");

    // R9: restart a multiply with a divide mid-way, and a divide with a multiply
    pulse(1'b0, 16'h00E7, 8'h9D);
    repeat (3) tick();
    pulse(1'b1, 16'd40000, 8'd13);
    finish_op(1'b1, 40000, 13);
    chk("R9", longint'(quot_mplr_o), 40000 / 13, "restart quotient");
    pulse(1'b1, 16'd999, 8'd3);
    repeat (7) tick();
    pulse(1'b0, 16'h0021, 8'h42);
    finish_op(1'b0, 33, 66);
    chk("R9", longint'(prod_rem_o), 33 * 66, "restart product");

    // mixed pseudo-random operations
    for (int i = 0; i < 40; i++) begin
      logic [W-1:0] a;
      logic [N-1:0] b;
      lcg = (lcg * 64'd6364136223846793005 + 64'd1442695040888963407);
      a = lcg[47:32];
      b = lcg[23:16];
      run(lcg[60], a, b);
    end

    report();
  end
endmodule